// File: doc/BRIEF.md
# Pipelined Floating-Point Vector Adder

This block adds two streams of single-precision floating-point numbers element by element and returns one sum per element. A vector is started with a one-cycle `start` pulse that carries the element count on `vec_len`. From the next cycle on, every cycle with `in_valid` high delivers one operand pair. Each pair passes through six registered stages: operand capture, exponent comparison, alignment shift, mantissa add or subtract, normalization and result packing. Up to six pairs are therefore in flight at once, and the block can accept one pair per clock.

A small sequencer counts the pairs it accepts and the results it sees leave. It tags each pair with its element index and raises `done` for one cycle once the last sum of the vector has appeared. The sequencer has four states. IDLE waits for `start`. In RUN, pairs are accepted and numbered. In DRAIN, input is closed and the sequencer waits for the remaining results. DONE is the one-cycle completion state. The transitions are named as follows: T_LOAD (IDLE to RUN, on `start` with a nonzero length), T_EMPTY (IDLE to DONE, on `start` with length zero), T_LAST_IN (RUN to DRAIN, when the final pair is accepted), T_LAST_OUT (DRAIN to DONE, when the final result appears) and T_RELEASE (DONE to IDLE).

The arithmetic covers normal numbers and zero. An exponent field of 0 is read as zero, and rounding is by truncation. Denormal results, infinities, NaN and exception flags are not handled.

Top module: `vfa_vector_adder`

## Requirements
- R1: A pair accepted at clock edge e produces its result on `out_sum` and `out_valid` directly after edge e+5. This is six register stages, counting the capture edge.
- R2: A pair is accepted on every clock in RUN with `in_valid` high. Back-to-back pairs give results on consecutive cycles. Idle input cycles appear as `out_valid` low in the same positions, six cycles later.
- R3: The operand with the smaller magnitude is shifted right by the exponent difference. Bits shifted out are discarded before the add. A difference of 24 or more turns that operand into zero, so the sum equals the larger operand exactly.
- R4: When the signs are equal, the mantissas are added. On a carry out, the sum is shifted right by one, the dropped bit is discarded, and the exponent is incremented.
- R5: When the signs differ, the smaller magnitude is subtracted from the larger. The result takes the sign of the larger-magnitude operand and is normalized left by its leading-zero count, with the exponent reduced to match.
- R6: An exact zero result is encoded as 32'h00000000 (never -0). This covers cancellation, zero plus zero, and results whose exponent would fall to 0 or below. Adding zero to a number x returns x unchanged.
- R7: For any operands that are normal or zero, and whose sum does not overflow, the result differs from the exact sum by less than three units in the last place of the larger operand. The result has the sign of the exact sum. For equal signs, its magnitude never exceeds the exact one.
- R8: `start` in IDLE loads `vec_len`. The sequencer takes T_LOAD for a nonzero length and T_EMPTY for length zero. `done` is high for exactly one cycle: the cycle after the last result of the vector appears, or the cycle after `start` when the length is zero.
- R9: `in_valid` outside RUN is ignored and yields no result. `start` outside IDLE is ignored, and the running vector keeps its original length.
- R10: `out_idx` carries the element index of each result. The index starts at 0 for every vector and increments by one per accepted pair.
- R11: While reset is asserted, and right after it is released, `out_valid` and `done` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | One-cycle pulse in IDLE that begins a vector |
| vec_len | input | LEN_W | Number of element pairs, sampled with `start` |
| in_valid | input | 1 | Operand pair on `in_a`/`in_b` is present |
| in_a | input | 32 | First operand, single precision |
| in_b | input | 32 | Second operand, single precision |
| out_valid | output | 1 | `out_sum` and `out_idx` hold a result |
| out_idx | output | LEN_W | Element index of the result |
| out_sum | output | 32 | Sum, single precision, truncated |
| done | output | 1 | One-cycle pulse after the last result of a vector |

## Verification
A wrong datapath register shows up as a wrong sum six cycles after the affected pair enters. It is caught by the exact-code checks on crafted operands, or by the truncation bound over the sweep of exponent differences, sign pairs and mantissa patterns. A wrong sideband or sequencer state shows at once on the next result. It appears as a latency other than six, an index out of order, a result outside a vector, or a `done` pulse that is missing, late or repeated.

// File: rtl/vfa_pkg.sv
package vfa_pkg;
    localparam int EXP_W  = 8;
    localparam int FRAC_W = 23;
    localparam int FP_W   = 1 + EXP_W + FRAC_W;
    localparam int MANT_W = FRAC_W + 1;
    localparam int DEPTH  = 6;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_RUN,
        ST_DRAIN,
        ST_DONE
    } seq_state_e;

    typedef struct packed {
        logic              sgn;
        logic [EXP_W-1:0]  ex;
        logic [MANT_W-1:0] man;
    } unp_t;

    function automatic unp_t fp_unpack(input logic [FP_W-1:0] w);
        unp_t u;
        u.sgn = w[FP_W-1];
        u.ex  = w[FP_W-2 -: EXP_W];
        u.man = (u.ex == '0) ? '0 : {1'b1, w[FRAC_W-1:0]};
        return u;
    endfunction
endpackage

// File: rtl/vfa_lzc.sv
module vfa_lzc #(
    parameter int W  = 24,
    parameter int CW = $clog2(W + 1)
) (
    input  logic [W-1:0]  vec,
    output logic [CW-1:0] zeros
);
    always_comb begin
        zeros = CW'(W);
        for (int i = 0; i < W; i++) begin
            if (vec[i]) begin
                zeros = CW'(W - 1 - i);
            end
        end
    end
endmodule

// File: rtl/vfa_seq_ctrl.sv
module vfa_seq_ctrl
    import vfa_pkg::*;
#(
    parameter int LEN_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [LEN_W-1:0] vec_len,
    input  logic             in_valid,
    input  logic             res_valid,
    output logic             accept,
    output logic [LEN_W-1:0] acc_idx,
    output logic             done
);
    seq_state_e       state_q, state_d;
    logic [LEN_W-1:0] len_q, acc_cnt_q, res_cnt_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start) begin
                    state_d = (vec_len == '0) ? ST_DONE : ST_RUN;
                end
            end
            ST_RUN: begin
                if (in_valid && acc_cnt_q == len_q - 1'b1) begin
                    state_d = ST_DRAIN;
                end
            end
            ST_DRAIN: begin
                if (res_valid && res_cnt_q == len_q - 1'b1) begin
                    state_d = ST_DONE;
                end
            end
            ST_DONE: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            len_q     <= '0;
            acc_cnt_q <= '0;
            res_cnt_q <= '0;
        end else if (state_q == ST_IDLE && start) begin
            len_q     <= vec_len;
            acc_cnt_q <= '0;
            res_cnt_q <= '0;
        end else begin
            if (accept) begin
                acc_cnt_q <= acc_cnt_q + 1'b1;
            end
            if (res_valid && (state_q == ST_RUN || state_q == ST_DRAIN)) begin
                res_cnt_q <= res_cnt_q + 1'b1;
            end
        end
    end

    always_comb begin
        accept  = (state_q == ST_RUN) && in_valid;
        done    = (state_q == ST_DONE);
        acc_idx = acc_cnt_q;
    end

    // R8: completion lasts exactly one cycle
    a_r8_done_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R8: an empty vector completes right after start
    a_r8_empty_completes: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && start && vec_len == '0) |=> done);
    // R9: no more pairs than the loaded length
    a_r9_accept_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        accept |-> (acc_cnt_q < len_q));
    // R9: results leave the pipeline only while a vector is open
    a_r9_result_in_window: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> (state_q == ST_RUN || state_q == ST_DRAIN));
endmodule

// File: rtl/vfa_add_pipe.sv
module vfa_add_pipe
    import vfa_pkg::*;
#(
    parameter int IDX_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [IDX_W-1:0] in_idx,
    input  logic [FP_W-1:0]  in_x,
    input  logic [FP_W-1:0]  in_y,
    output logic             out_valid,
    output logic [IDX_W-1:0] out_idx,
    output logic [FP_W-1:0]  out_sum
);
    localparam int LZ_W   = $clog2(MANT_W + 1);
    localparam int EXPX_W = EXP_W + 1;

    // sideband: valid and index ride along all six stages
    logic [DEPTH-1:0]            vld_q;
    logic [DEPTH-1:0][IDX_W-1:0] tag_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vld_q <= '0;
        end else begin
            vld_q <= {vld_q[DEPTH-2:0], in_valid};
        end
    end

    always_ff @(posedge clk) begin
        tag_q <= {tag_q[DEPTH-2:0], in_idx};
    end

    // stage 1: operand capture
    logic [FP_W-1:0] s1_x, s1_y;
    always_ff @(posedge clk) begin
        s1_x <= in_x;
        s1_y <= in_y;
    end

    // stage 2: exponent comparison, order by magnitude
    unp_t             c2_x, c2_y, c2_big, c2_sml;
    unp_t             s2_big;
    logic             s2_sml_sgn;
    logic [MANT_W-1:0] s2_sml_man;
    logic [EXP_W-1:0] s2_diff;

    always_comb begin
        c2_x = fp_unpack(s1_x);
        c2_y = fp_unpack(s1_y);
        if ({c2_x.ex, c2_x.man} >= {c2_y.ex, c2_y.man}) begin
            c2_big = c2_x;
            c2_sml = c2_y;
        end else begin
            c2_big = c2_y;
            c2_sml = c2_x;
        end
    end

    always_ff @(posedge clk) begin
        s2_big     <= c2_big;
        s2_sml_sgn <= c2_sml.sgn;
        s2_sml_man <= c2_sml.man;
        s2_diff    <= c2_big.ex - c2_sml.ex;
    end

    // stage 3: alignment shift with truncation
    logic [MANT_W-1:0] c3_man;
    unp_t              s3_big;
    logic              s3_sml_sgn;
    logic [MANT_W-1:0] s3_sml_man;

    always_comb begin
        if (s2_diff >= EXP_W'(MANT_W)) begin
            c3_man = '0;
        end else begin
            c3_man = s2_sml_man >> s2_diff;
        end
    end

    always_ff @(posedge clk) begin
        s3_big     <= s2_big;
        s3_sml_sgn <= s2_sml_sgn;
        s3_sml_man <= c3_man;
    end

    // stage 4: mantissa add or subtract
    logic [MANT_W:0]  c4_raw;
    logic             s4_sgn;
    logic [EXP_W-1:0] s4_ex;
    logic [MANT_W:0]  s4_raw;

    always_comb begin
        if (s3_big.sgn != s3_sml_sgn) begin
            c4_raw = {1'b0, s3_big.man} - {1'b0, s3_sml_man};
        end else begin
            c4_raw = {1'b0, s3_big.man} + {1'b0, s3_sml_man};
        end
    end

    always_ff @(posedge clk) begin
        s4_sgn <= s3_big.sgn;
        s4_ex  <= s3_big.ex;
        s4_raw <= c4_raw;
    end

    // stage 5: normalization
    logic [LZ_W-1:0] c5_lz;
    unp_t            c5_res;
    unp_t            s5_res;

    vfa_lzc #(.W(MANT_W), .CW(LZ_W)) i_lzc (
        .vec   (s4_raw[MANT_W-1:0]),
        .zeros (c5_lz)
    );

    always_comb begin
        c5_res.sgn = s4_sgn;
        c5_res.ex  = s4_ex;
        c5_res.man = s4_raw[MANT_W-1:0];
        if (s4_raw[MANT_W]) begin
            c5_res.ex  = s4_ex + 1'b1;
            c5_res.man = s4_raw[MANT_W:1];
        end else if (s4_raw == '0 || {1'b0, s4_ex} <= EXPX_W'(c5_lz)) begin
            c5_res = '0;
        end else begin
            c5_res.ex  = s4_ex - EXP_W'(c5_lz);
            c5_res.man = s4_raw[MANT_W-1:0] << c5_lz;
        end
    end

    always_ff @(posedge clk) begin
        s5_res <= c5_res;
    end

    // stage 6: result register
    logic [FP_W-1:0] c6_word, s6_word;

    always_comb begin
        if (!s5_res.man[MANT_W-1]) begin
            c6_word = '0;
        end else begin
            c6_word = {s5_res.sgn, s5_res.ex, s5_res.man[FRAC_W-1:0]};
        end
    end

    always_ff @(posedge clk) begin
        s6_word <= c6_word;
    end

    assign out_valid = vld_q[DEPTH-1];
    assign out_idx   = tag_q[DEPTH-1];
    assign out_sum   = s6_word;

    // R1: a result leaves six edges after its pair entered
    a_r1_valid_latency: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid == $past(in_valid, 6));
    // R10: the index leaves with its own result
    a_r10_idx_carried: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_idx == $past(in_idx, 6)));
    // R6: zero is always the positive encoding
    a_r6_no_neg_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_sum[FP_W-2:0] == '0) |-> !out_sum[FP_W-1]);
endmodule

// File: rtl/vfa_vector_adder.sv
module vfa_vector_adder
    import vfa_pkg::*;
#(
    parameter int LEN_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [LEN_W-1:0] vec_len,
    input  logic             in_valid,
    input  logic [FP_W-1:0]  in_a,
    input  logic [FP_W-1:0]  in_b,
    output logic             out_valid,
    output logic [LEN_W-1:0] out_idx,
    output logic [FP_W-1:0]  out_sum,
    output logic             done
);
    logic             accept;
    logic [LEN_W-1:0] acc_idx;

    vfa_seq_ctrl #(.LEN_W(LEN_W)) i_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .vec_len   (vec_len),
        .in_valid  (in_valid),
        .res_valid (out_valid),
        .accept    (accept),
        .acc_idx   (acc_idx),
        .done      (done)
    );

    vfa_add_pipe #(.IDX_W(LEN_W)) i_pipe (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (accept),
        .in_idx    (acc_idx),
        .in_x      (in_a),
        .in_y      (in_b),
        .out_valid (out_valid),
        .out_idx   (out_idx),
        .out_sum   (out_sum)
    );
endmodule

// File: tb/test_vfa_vector_adder.sv
`timescale 1ns/1ps
module test_vfa_vector_adder;
    localparam int LEN_W = 10;
    localparam int MAXN  = 1 << LEN_W;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start = 1'b0;
    logic [LEN_W-1:0] vec_len = '0;
    logic             in_valid = 1'b0;
    logic [31:0]      in_a = '0;
    logic [31:0]      in_b = '0;
    logic             out_valid;
    logic [LEN_W-1:0] out_idx;
    logic [31:0]      out_sum;
    logic             done;

    vfa_vector_adder #(.LEN_W(LEN_W)) i_vfa_vector_adder (
        .clk(clk), .rst_n(rst_n), .start(start), .vec_len(vec_len),
        .in_valid(in_valid), .in_a(in_a), .in_b(in_b),
        .out_valid(out_valid), .out_idx(out_idx), .out_sum(out_sum), .done(done)
    );

    always #2.5 clk = ~clk;

    int checks = 0, errors = 0, cyc = 0;
    logic [31:0] ta [MAXN];
    logic [31:0] tb [MAXN];
    logic [31:0] tx [MAXN];
    bit          tex [MAXN];
    string       treq [MAXN];
    int          tacc [MAXN];
    int cur_len = 0, next_out = 0, last_out_cyc = -100, first_out_cyc = 0;
    int done_due = 0, n_out_total = 0;
    bit done_seen = 0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic real f2r(input logic [31:0] w);
        real m;
        int  e;
        if (w[30:23] == 8'd0) return 0.0;
        e = int'(w[30:23]) - 127;
        m = (1.0 + real'(w[22:0]) / 8388608.0) * (2.0 ** e);
        return w[31] ? -m : m;
    endfunction

    function automatic real rabs(input real v);
        return (v < 0.0) ? -v : v;
    endfunction

    // result monitor, sampled on the falling edge
    always @(negedge clk) begin
        if (rst_n) begin
            if (out_valid) begin
                n_out_total++;
                if (next_out >= cur_len) begin
                    chk(1'b0, "R9", "result outside a vector", 32'(out_idx), 32'(cur_len));
                end else begin
                    automatic int  i = next_out;
                    automatic real ex = f2r(ta[i]) + f2r(tb[i]);
                    automatic real g  = f2r(out_sum);
                    automatic int  ea = int'(ta[i][30:23]);
                    automatic int  eb = int'(tb[i][30:23]);
                    automatic real ulp = 2.0 ** (((ea > eb) ? ea : eb) - 150);
                    automatic bit  ok;
                    chk(int'(out_idx) == i, "R10", "element index", 32'(out_idx), 32'(i));
                    chk(cyc - tacc[i] == 6, "R1", "latency", 32'(cyc - tacc[i]), 32'd6);
                    if (tex[i]) begin
                        chk(out_sum == tx[i], treq[i], "exact sum", out_sum, tx[i]);
                    end else begin
                        if (ex == 0.0) ok = (out_sum == 32'h0);
                        else begin
                            ok = rabs(g - ex) < 3.0 * ulp;
                            if (g != 0.0) ok = ok && ((g < 0.0) == (ex < 0.0));
                            if (ta[i][31] == tb[i][31]) ok = ok && (rabs(g) <= rabs(ex));
                        end
                        chk(ok, "R7", "truncation bound", out_sum, ta[i]);
                    end
                    if (i == 0) first_out_cyc = cyc;
                    last_out_cyc = cyc;
                    next_out++;
                end
            end
            if (done) begin
                if (cur_len == 0)
                    chk(cyc == done_due, "R8", "done after empty start", 32'(cyc), 32'(done_due));
                else
                    chk(next_out == cur_len && cyc == last_out_cyc + 1, "R8",
                        "done after last result", 32'(cyc), 32'(last_out_cyc + 1));
                done_seen = 1'b1;
            end
        end
    end

    task automatic run_vec(input int n, input int gap, input bit poke);
        @(negedge clk);
        start = 1'b1; vec_len = LEN_W'(n);
        cur_len = n; next_out = 0; done_seen = 1'b0; done_due = cyc + 1;
        @(negedge clk);
        start = 1'b0;
        for (int i = 0; i < n; i++) begin
            if (gap > 0 && (i % gap) == gap - 1) begin
                in_valid = 1'b0;
                @(negedge clk);
            end
            in_valid = 1'b1; in_a = ta[i]; in_b = tb[i]; tacc[i] = cyc;
            if (poke && i == 2) begin
                start = 1'b1; vec_len = LEN_W'(3);   // R9: must be ignored
            end
            @(negedge clk);
            start = 1'b0;
        end
        in_valid = 1'b0;
        repeat (12) @(negedge clk);
        chk(done_seen && next_out == n, "R8", "vector completed", 32'(next_out), 32'(n));
    endtask

    task automatic put(input int i, input logic [31:0] a, input logic [31:0] b,
                       input logic [31:0] x, input string req);
        ta[i] = a; tb[i] = b; tx[i] = x; tex[i] = 1'b1; treq[i] = req;
    endtask

    initial begin
        #500000;
        checks++; errors++;
        $display("FAIL watchdog: run did not end, actual %0d cycles expected fewer", cyc);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int n;
        repeat (10) @(negedge clk);
        chk(!out_valid && !done, "R11", "outputs in reset", {30'b0, out_valid, done}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!out_valid && !done, "R11", "outputs after reset", {30'b0, out_valid, done}, 32'h0);

        // directed exact cases, streamed back to back
        put(0,  32'h3FC00000, 32'h3FC00000, 32'h40400000, "R4");
        put(1,  32'h3F800000, 32'hBF800000, 32'h00000000, "R6");
        put(2,  32'h40400000, 32'hBF800000, 32'h40000000, "R5");
        put(3,  32'h3F800000, 32'h30800000, 32'h3F800000, "R3");
        put(4,  32'h3F800000, 32'h3F000001, 32'h3FC00000, "R3");
        put(5,  32'h3F800001, 32'h3F800000, 32'h40000000, "R4");
        put(6,  32'h00C00000, 32'h80800000, 32'h00000000, "R6");
        put(7,  32'h00000000, 32'h00000000, 32'h00000000, "R6");
        put(8,  32'h40A00000, 32'h00000000, 32'h40A00000, "R6");
        put(9,  32'hBF800000, 32'h3E800000, 32'hBF400000, "R5");
        put(10, 32'h3E800000, 32'hBF800000, 32'hBF400000, "R5");
        put(11, 32'h3F800000, 32'hBF7FFFFF, 32'h34000000, "R5");
        put(12, 32'h3F800000, 32'h33800000, 32'h3F800000, "R3");
        put(13, 32'h3F800000, 32'h34000000, 32'h3F800001, "R3");
        put(14, 32'h71800000, 32'h71800000, 32'h72000000, "R4");
        put(15, 32'h80000000, 32'h80000000, 32'h00000000, "R6");
        run_vec(16, 0, 1'b1);
        chk(last_out_cyc - first_out_cyc == 15, "R2", "back-to-back result spacing",
            32'(last_out_cyc - first_out_cyc), 32'd15);

        // sweep: exponent differences x sign pairs x mantissa patterns, with bubbles
        n = 0;
        for (int d = 0; d < 28; d++) begin
            for (int sg = 0; sg < 4; sg++) begin
                for (int p = 0; p < 3; p++) begin
                    automatic logic [22:0] fa = (p == 0) ? 23'h0 : (p == 1) ? 23'h7FFFFF : 23'h2AAAAB;
                    automatic logic [22:0] fb = (p == 0) ? 23'h400000 : (p == 1) ? 23'h000001 : 23'h555555;
                    automatic logic [7:0]  ea = (p == 2) ? 8'(130 - d) : 8'd130;
                    automatic logic [7:0]  eb = (p == 2) ? 8'd130 : 8'(130 - d);
                    ta[n] = {sg[1], ea, fa};
                    tb[n] = {sg[0], eb, fb};
                    tex[n] = 1'b0;
                    n++;
                end
            end
        end
        run_vec(n, 4, 1'b0);

        // R8: empty vector
        run_vec(0, 0, 1'b0);

        // R9: valid input while idle gives nothing
        n = n_out_total;
        for (int k = 0; k < 8; k++) begin
            @(negedge clk);
            in_valid = 1'b1; in_a = 32'h3F800000; in_b = 32'h3F800000;
        end
        @(negedge clk);
        in_valid = 1'b0;
        repeat (10) @(negedge clk);
        chk(n_out_total == n, "R9", "idle input ignored", 32'(n_out_total), 32'(n));

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule